// File: doc/BRIEF.md
# Interrupt Source Conditioner

This block sits between a bank of raw interrupt wires and the rest of an interrupt controller. It brings each wire into the clock domain and applies a per-line sense: either active-high or active-low level, or edge capture on one chosen edge or on both edges. Software can also inject or retract an edge event on any line. A per-line enable mask gates the conditioned status onto a pending vector. The next stage, which handles routing and priority, consumes that vector directly.

Software programs the block through a 32-bit, word-addressed register bus that has a write strobe and a combinational read path. Line state is packed 32 lines per word, with line n at word n/32 and bit n%32. Enables are never written directly. They change only through a write-one-to-set port and a write-one-to-clear port, and their current value is read back from a read-only view.

Top module: `irq_cond`

## Requirements
- R1: After reset the polarity, trigger, dual-edge and enable registers, every latched edge and the pending output are all zero. Polarity and trigger at zero select active-low level sensing.
- R2: `bus_addr[5:3]` selects a group and `bus_addr[2:0]` selects a word. The groups are 0 polarity, 1 trigger, 2 dual-edge, 3 enable-set (write only, reads 0), 4 enable-clear (write only, reads 0), 5 enable view (read only), 6 pending view (read only) and 7 edge injection (word 0). Line n sits at word n/32, bit n%32. Bits and words beyond the last line read 0. Writes to groups 5 and 6 are ignored.
- R3: A line in level mode (trigger bit 0) is pending when it is enabled and its input equals its polarity bit (1 = high, 0 = low). The pending output reflects an input change after two clock edges, because of a two-flop synchronizer.
- R4: A line in edge mode (trigger bit 1, dual bit 0) latches on a rising input when its polarity is 1 and on a falling input when its polarity is 0. The pending output shows the event three clock edges after the input change. The latch holds until software clears it, even after the input returns.
- R5: A line in edge mode whose dual-edge bit is 1 latches on both rising and falling input transitions.
- R6: Writing group 3 sets the enable of every line whose data bit is 1. Lines whose data bit is 0 keep their enable.
- R7: Writing group 4 clears the enable of every line whose data bit is 1. Lines whose data bit is 0 keep their enable.
- R8: A write to group 7 with data bit 31 set latches an edge on the line numbered by data bits 7:0. With bit 31 clear, the same write clears that line's latch. A line number at or beyond the line count has no effect.
- R9: When a hardware edge and a software clear hit the same line on the same clock edge, the line ends up latched.
- R10: The pending output and the group 6 view equal the conditioned status ANDed with the enables. A disabled line never shows as pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, takes effect at the clock edge |
| bus_addr | input | 6 | Word address: group in bits 5:3, word in bits 2:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | NUM_LINES | Raw, asynchronous interrupt lines |
| irq_pend | output | NUM_LINES | Enabled and asserted lines |

## Verification
A wrong configuration bit shows within one edge after its write: the enable or pending view changes, or a level line flips sense in the pending output. A broken synchronizer or edge detector moves the cycle at which a line appears. The bench samples one cycle before and on the cycle where the change is due, so an early or late edge is caught at once. A latch that leaks, sticks or ignores the hardware-wins rule is exposed by reading the pending vector right after the clear and again several cycles later, while the input is held quiet.

// File: rtl/irq_cond_pkg.sv
// Shared constants and types for the interrupt source conditioner.
// Assumes at most 256 lines, so 8 words of 32 bits.
package irq_cond_pkg;
    localparam int WORD_BITS    = 32;
    localparam int MAX_LINES    = 256;
    localparam int IDX_W        = 3;
    localparam int GRP_W        = 3;
    localparam int ADDR_W       = GRP_W + IDX_W;
    localparam int LINE_FIELD_W = 8;
    localparam int INJ_SET_BIT  = 31;

    typedef enum logic [GRP_W-1:0] {
        GRP_POL  = 3'd0,
        GRP_TRIG = 3'd1,
        GRP_DUAL = 3'd2,
        GRP_MSET = 3'd3,
        GRP_MCLR = 3'd4,
        GRP_MASK = 3'd5,
        GRP_PEND = 3'd6,
        GRP_INJ  = 3'd7
    } grp_e;

    typedef struct packed {
        logic                 wr;
        grp_e                 grp;
        logic [IDX_W-1:0]     word;
        logic [WORD_BITS-1:0] data;
    } bus_cmd_t;
endpackage

// File: rtl/irq_cond_sync.sv
// Multi-stage flop synchronizer for a vector of asynchronous lines.
// Assumes each bit is independent, so no bus coherence is required.
module irq_cond_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First capture flop for the raw lines
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_in;
                end
            end else begin : g_next
                // Further settling flops
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[i] <= '0;
                    else        stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_cond_regs.sv
// Register file: per-line polarity, trigger, dual-edge and enable bits,
// decode of the set/clear enable ports and the edge-injection word,
// and the read multiplexer.
// Assumes one bus command per cycle, so set and clear never coincide.
module irq_cond_regs
    import irq_cond_pkg::*;
#(
    parameter int NUM_LINES = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  bus_cmd_t             cmd,
    input  grp_e                 rd_grp,
    input  logic [IDX_W-1:0]     rd_word,
    input  logic [NUM_LINES-1:0] pend,
    output logic [NUM_LINES-1:0] pol,
    output logic [NUM_LINES-1:0] trig,
    output logic [NUM_LINES-1:0] dual,
    output logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] sw_set,
    output logic [NUM_LINES-1:0] sw_clr,
    output logic [WORD_BITS-1:0] rdata
);
    logic inj_hit;
    assign inj_hit = cmd.wr && (cmd.grp == GRP_INJ) && (cmd.word == '0);

    genvar n;
    generate
        for (n = 0; n < NUM_LINES; n++) begin : g_line
            localparam int WI = n / WORD_BITS;
            localparam int BI = n % WORD_BITS;
            localparam logic [IDX_W-1:0]        WSEL = WI[IDX_W-1:0];
            localparam logic [LINE_FIELD_W-1:0] LID  = n[LINE_FIELD_W-1:0];
            logic word_hit;
            assign word_hit = cmd.wr && (cmd.word == WSEL);

            // Configuration bits written in place
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pol[n]  <= 1'b0;
                    trig[n] <= 1'b0;
                    dual[n] <= 1'b0;
                end else if (word_hit) begin
                    if (cmd.grp == GRP_POL)  pol[n]  <= cmd.data[BI];
                    if (cmd.grp == GRP_TRIG) trig[n] <= cmd.data[BI];
                    if (cmd.grp == GRP_DUAL) dual[n] <= cmd.data[BI];
                end
            end

            // Enable bit changed only through set and clear ports
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mask[n] <= 1'b0;
                end else if (word_hit && cmd.data[BI]) begin
                    if (cmd.grp == GRP_MSET)      mask[n] <= 1'b1;
                    else if (cmd.grp == GRP_MCLR) mask[n] <= 1'b0;
                end
            end

            // Edge-injection decode for this line
            assign sw_set[n] = inj_hit && (cmd.data[LINE_FIELD_W-1:0] == LID) &&  cmd.data[INJ_SET_BIT];
            assign sw_clr[n] = inj_hit && (cmd.data[LINE_FIELD_W-1:0] == LID) && !cmd.data[INJ_SET_BIT];

            p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd.wr && cmd.grp == GRP_MSET && cmd.word == WSEL && cmd.data[BI]) |=> mask[n]);
            p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd.wr && cmd.grp == GRP_MCLR && cmd.word == WSEL && cmd.data[BI]) |=> !mask[n]);
        end
    endgenerate

    logic [MAX_LINES-1:0] pol_pad, trig_pad, dual_pad, mask_pad, pend_pad;

    // Zero-extend every per-line view to the full 256-line span
    always_comb begin
        pol_pad  = '0;
        trig_pad = '0;
        dual_pad = '0;
        mask_pad = '0;
        pend_pad = '0;
        pol_pad[NUM_LINES-1:0]  = pol;
        trig_pad[NUM_LINES-1:0] = trig;
        dual_pad[NUM_LINES-1:0] = dual;
        mask_pad[NUM_LINES-1:0] = mask;
        pend_pad[NUM_LINES-1:0] = pend;
    end

    // Read multiplexer: group picks the vector, word picks the slice
    always_comb begin
        unique case (rd_grp)
            GRP_POL:  rdata = pol_pad [int'(rd_word)*WORD_BITS +: WORD_BITS];
            GRP_TRIG: rdata = trig_pad[int'(rd_word)*WORD_BITS +: WORD_BITS];
            GRP_DUAL: rdata = dual_pad[int'(rd_word)*WORD_BITS +: WORD_BITS];
            GRP_MASK: rdata = mask_pad[int'(rd_word)*WORD_BITS +: WORD_BITS];
            GRP_PEND: rdata = pend_pad[int'(rd_word)*WORD_BITS +: WORD_BITS];
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_cond_detect.sv
// Per-line sense logic: level compare, single or dual edge capture,
// edge latch with software set/clear, and enable gating.
// Assumes synchronized inputs; a hardware edge outranks a software clear.
module irq_cond_detect #(
    parameter int NUM_LINES = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] s_in,
    input  logic [NUM_LINES-1:0] pol,
    input  logic [NUM_LINES-1:0] trig,
    input  logic [NUM_LINES-1:0] dual,
    input  logic [NUM_LINES-1:0] mask,
    input  logic [NUM_LINES-1:0] sw_set,
    input  logic [NUM_LINES-1:0] sw_clr,
    output logic [NUM_LINES-1:0] pend
);
    logic [NUM_LINES-1:0] s_q, edge_q, hw_edge;

    // Previous synchronized value, used for transition detection
    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_in;
    end

    genvar n;
    generate
        for (n = 0; n < NUM_LINES; n++) begin : g_line
            logic rise, fall, sel_edge, level_act;
            assign rise      = s_in[n] & ~s_q[n];
            assign fall      = ~s_in[n] & s_q[n];
            assign sel_edge  = dual[n] ? (rise | fall) : (pol[n] ? rise : fall);
            assign hw_edge[n] = trig[n] & sel_edge;
            assign level_act = (s_in[n] == pol[n]);

            // Edge latch: hardware edge or software set wins over clear
            always_ff @(posedge clk) begin
                if (!rst_n)                      edge_q[n] <= 1'b0;
                else if (hw_edge[n] || sw_set[n]) edge_q[n] <= 1'b1;
                else if (sw_clr[n])              edge_q[n] <= 1'b0;
            end

            assign pend[n] = mask[n] & (trig[n] ? edge_q[n] : level_act);
        end
    endgenerate

    p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_edge != '0) |=> ((edge_q & $past(hw_edge)) == $past(hw_edge)));
    p_sw_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_clr & ~hw_edge) != '0) |=> ((edge_q & $past(sw_clr & ~hw_edge)) == '0));
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_q != '0) |=> ((edge_q & $past(edge_q & ~sw_clr)) == $past(edge_q & ~sw_clr)));
endmodule

// File: rtl/irq_cond.sv
// Top of the interrupt source conditioner: splits the bus address,
// synchronizes the raw lines and wires register file to sense logic.
// Assumes NUM_LINES between 1 and 256.
module irq_cond
    import irq_cond_pkg::*;
#(
    parameter int NUM_LINES   = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [5:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_pend
);
    bus_cmd_t             cmd;
    grp_e                 grp;
    logic [NUM_LINES-1:0] s_sync, pol, trig, dual, mask, sw_set, sw_clr;

    assign grp      = grp_e'(bus_addr[ADDR_W-1:IDX_W]);
    assign cmd.wr   = bus_wr;
    assign cmd.grp  = grp;
    assign cmd.word = bus_addr[IDX_W-1:0];
    assign cmd.data = bus_wdata;

    irq_cond_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(irq_in), .q_out(s_sync)
    );

    irq_cond_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .cmd(cmd),
        .rd_grp(grp), .rd_word(bus_addr[IDX_W-1:0]), .pend(irq_pend),
        .pol(pol), .trig(trig), .dual(dual), .mask(mask),
        .sw_set(sw_set), .sw_clr(sw_clr), .rdata(bus_rdata)
    );

    irq_cond_detect #(.NUM_LINES(NUM_LINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .s_in(s_sync),
        .pol(pol), .trig(trig), .dual(dual), .mask(mask),
        .sw_set(sw_set), .sw_clr(sw_clr), .pend(irq_pend)
    );

    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && grp == GRP_MCLR && bus_wdata != '0 && bus_addr[IDX_W-1:0] == '0)
        |=> ((irq_pend[NUM_LINES-1:0] & NUM_LINES'($past(bus_wdata))) == '0));
endmodule

// File: tb/irq_cond_tb_top.sv
// Scoreboard bench: driver tasks queue expected values, a monitor
// compares them against the ports shortly after each falling edge.
module irq_cond_tb_top;
    localparam int NL = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] irq_in = '0;
    logic [NL-1:0] irq_pend;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_pend;
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    irq_cond #(.NUM_LINES(NL)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_pend(irq_pend)
    );

    // Monitor: pop queued expectations and compare against the ports
    always @(negedge clk) begin
        #3;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it = sb_q.pop_front();
            act = it.is_pend ? 64'(irq_pend) : 64'(bus_rdata);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    // All tasks start and end at a falling edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        #1;
        it.is_pend = 1'b0; it.exp = 64'(e); it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic chk_pend(input logic [63:0] e, input string tag);
        item_t it;
        #1;
        it.is_pend = 1'b1; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(3);
        // R1 reset state
        chk_rd(6'd0,  32'h0, "R1 polarity");
        chk_rd(6'd8,  32'h0, "R1 trigger");
        chk_rd(6'd40, 32'h0, "R1 enable");
        chk_pend(64'h0, "R1 pending");
        // R6 set enables; inputs low, active-low level lines assert
        wr(6'd24, 32'h0000_00F0);
        chk_rd(6'd40, 32'hF0, "R6 enable view");
        chk_pend(64'hF0, "R10 pending after set");
        // R7 clear some enables, others kept
        wr(6'd32, 32'h0000_0030);
        chk_rd(6'd40, 32'hC0, "R7 enable view");
        chk_pend(64'hC0, "R7 pending after clear");
        // R2 upper word, partial lines, unused word, read-only groups
        wr(6'd25, 32'hFFFF_FFFF);
        chk_rd(6'd41, 32'h0000_00FF, "R2 upper enable word");
        chk_rd(6'd42, 32'h0, "R2 unused word");
        chk_rd(6'd49, 32'h0000_00FF, "R10 upper pending word");
        chk_rd(6'd26, 32'h0, "R2 set port reads zero");
        wr(6'd40, 32'hFFFF_FFFF);
        chk_rd(6'd40, 32'hC0, "R2 read-only enable view");
        wr(6'd33, 32'hFFFF_FFFF);
        chk_rd(6'd41, 32'h0, "R7 upper cleared");
        // R3 polarity and two-edge level latency
        wr(6'd0, 32'h0000_0040);
        chk_pend(64'h80, "R3 line6 high sense");
        irq_in[6] = 1'b1;
        idle(1);
        chk_pend(64'h80, "R3 one edge after change");
        chk_pend(64'hC0, "R3 two edges after change");
        irq_in[7] = 1'b1;
        idle(2);
        chk_pend(64'h40, "R3 active-low released");
        // R4 rising edge capture on line 4
        wr(6'd0, 32'h0000_0050);
        wr(6'd8, 32'h0000_0010);
        wr(6'd24, 32'h0000_0010);
        chk_pend(64'h40, "R4 no latch yet");
        irq_in[4] = 1'b1;
        idle(2);
        chk_pend(64'h40, "R4 two edges after change");
        chk_pend(64'h50, "R4 three edges after change");
        irq_in[4] = 1'b0;
        idle(4);
        chk_pend(64'h50, "R4 latch holds");
        // R8 clear through injection word
        wr(6'd56, 32'h0000_0004);
        chk_pend(64'h40, "R8 software clear");
        chk_rd(6'd48, 32'h40, "R10 pending view");
        // R5 dual edge
        wr(6'd16, 32'h0000_0010);
        irq_in[4] = 1'b1;
        idle(3);
        chk_pend(64'h50, "R5 rising captured");
        wr(6'd56, 32'h0000_0004);
        chk_pend(64'h40, "R5 cleared");
        irq_in[4] = 1'b0;
        idle(2);
        chk_pend(64'h40, "R5 falling not yet");
        chk_pend(64'h50, "R5 falling captured");
        wr(6'd56, 32'h0000_0004);
        chk_pend(64'h40, "R5 cleared again");
        // R8 software set and out-of-range line
        wr(6'd56, 32'h8000_0004);
        chk_pend(64'h50, "R8 software set");
        wr(6'd56, 32'h0000_0028);
        chk_pend(64'h50, "R8 out-of-range clear ignored");
        wr(6'd56, 32'h0000_0004);
        chk_pend(64'h40, "R8 clear after set");
        // R9 hardware edge and software clear on the same edge
        irq_in[4] = 1'b1;
        idle(2);
        wr(6'd56, 32'h0000_0004);
        chk_pend(64'h50, "R9 hardware edge wins");
        wr(6'd56, 32'h0000_0004);
        chk_pend(64'h40, "R9 later clear works");
        idle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule